// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a 512-byte, byte-wide nonvolatile memory model. A host drives chip select, serial clock and serial data in SPI mode 0; the block oversamples those pins in its own faster system clock, decodes an 8-bit instruction, collects a 16-bit address and moves data bytes between the serial line and an internal byte array. Reads stream from any address with automatic increment and wrap at the top of the 9-bit address space. Programming gathers one 16-byte sector into a local buffer and copies it into the array only when the burst is complete and chip select rises on a byte boundary.

A write-enable flag, set and cleared by dedicated instructions, gates every program and status-write command, and is dropped after each committed write. Status reads return a byte supplied by an external protection controller; status writes hand the new byte to that controller through a one-cycle strobe. A self-timed write cycle, modelled as a cycle counter, keeps the block busy after each commit and blocks further writes while it runs. A program burst that ends on a byte boundary but is short, or that runs past its sector, raises a fault flag and leaves the array untouched.

Top module: `spi_mem_slave`

## Requirements
- R1: SI is sampled on SCK rising edges and SO changes only after SCK falling edges (SPI mode 0); instruction, address and data are all sent most significant bit first.
- R2: so_oe is low whenever CS is high, and high while an array read or status read is selected.
- R3: After reset no command is decoded until a high-to-low CS transition has been seen; with CS held low through reset, a full read command leaves so_oe low. Reset clears busy and prog_fault.
- R4: Instruction 0x03 followed by a 16-bit address streams bytes from address bits [8:0] (upper address bits ignored), incrementing after each byte.
- R5: A read stream wraps from address 0x1FF to 0x000 and continues while CS stays low.
- R6: Instruction 0x02 (program) and 0x01 (status write) are ignored unless the write-enable flag was set earlier by instruction 0x06.
- R7: A program of exactly 16 bytes starting at a sector-aligned address, with CS rising right after bit 0 of the last byte, writes the sector; the write-enable flag is cleared afterwards.
- R8: A CS rise in the middle of a data byte discards the program: the array is unchanged and prog_fault stays low.
- R9: A byte-aligned CS rise after fewer than 16 bytes, or after a burst that ran past the sector end, skips the commit and sets prog_fault; prog_fault clears at the next CS fall.
- R10: After a committed program or status write, busy is high for the self-timed cycle; a program or status-write instruction decoded while busy is ignored.
- R11: Instruction 0x05 returns stat_rdata, repeating every 8 bits while clocked; a byte that starts while busy is high reads as 0xFF.
- R12: Instruction 0x01 with write enable pulses stat_wr for one cycle with the data byte on stat_wdata at the CS rise; instruction 0x04 clears write enable.
- R13: An unknown opcode makes the block ignore SCK until CS goes high; SO stays disabled.
- R14: SCK may stop for any time between edges; the transfer resumes where it paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (high = drive) |
| stat_rdata | input | 8 | Status byte from protection controller |
| stat_wr | output | 1 | One-cycle strobe for a status write |
| stat_wdata | output | 8 | Status byte to write |
| busy | output | 1 | Self-timed write cycle in progress |
| prog_fault | output | 1 | Last program ended short or overran its sector |

## Verification
Every pin passes two synchroniser flops and an edge register, so a new SO bit appears about four system clocks after the SCK fall that requests it, and busy, prog_fault, stat_wr and so_oe settle within four clocks of a CS edge. The bench holds each SCK phase for eight system clocks and samples SO at the end of the low phase, just before raising SCK, and reads the status-type outputs three half periods after CS rises, so each sample lands well after its result is due. Array contents are checked only through read commands after busy has dropped, since the copy into the array and the write timer both run after the CS rise.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_PROG    = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,   // deselected or waiting for the first CS fall
    ST_CMD,    // shifting the instruction
    ST_ADDR,   // shifting the two address bytes
    ST_READ,   // streaming array data
    ST_STAT,   // streaming status
    ST_WSTAT,  // collecting a status byte
    ST_PROG,   // collecting sector data
    ST_SKIP    // ignoring the rest of the transfer
  } xfer_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_q,
  output logic si_q,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall
);

  logic [STAGES-1:0] cs_sh, sck_sh, si_sh;
  logic              sck_d, cs_d;

  // CS chain resets low so a host holding CS low through reset
  // never produces a falling edge: a real high-to-low is required.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sh  <= '0;
      sck_sh <= '0;
      si_sh  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
    end else begin
      cs_sh  <= {cs_sh[STAGES-2:0], cs_n};
      sck_sh <= {sck_sh[STAGES-2:0], sck};
      si_sh  <= {si_sh[STAGES-2:0], si};
      sck_d  <= sck_sh[STAGES-1];
      cs_d   <= cs_sh[STAGES-1];
    end
  end

  assign cs_q     = cs_sh[STAGES-1];
  assign si_q     = si_sh[STAGES-1];
  assign sck_rise = sck_sh[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_sh[STAGES-1] & sck_d;
  assign cs_rise  = cs_sh[STAGES-1] & ~cs_d;
  assign cs_fall  = ~cs_sh[STAGES-1] & cs_d;

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/spi_prog_timer.sv
module spi_prog_timer #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  assert_busy_after_start_R10: assert property (
    @(posedge clk) disable iff (rst) start |=> busy
  );

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W       = 9,
  parameter int unsigned SECTOR_BYTES = 16,
  parameter int unsigned PROG_CYCLES  = 400,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  input  logic [7:0] stat_rdata,
  output logic       stat_wr,
  output logic [7:0] stat_wdata,
  output logic       busy,
  output logic       prog_fault
);

  localparam int unsigned SEC_W  = $clog2(SECTOR_BYTES);
  localparam int unsigned BASE_W = ADDR_W - SEC_W;
  localparam int unsigned HI_W   = ADDR_W - 8;
  localparam logic [SEC_W:0]   FULL_CNT = (SEC_W+1)'(SECTOR_BYTES);
  localparam logic [SEC_W-1:0] LAST_IDX = SEC_W'(SECTOR_BYTES - 1);

  // synchronised pins and edge events
  logic cs_q, si_q, sck_rise, sck_fall, cs_rise, cs_fall;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .cs_q     (cs_q),
    .si_q     (si_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall)
  );

  xfer_state_t       state;
  logic [2:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [7:0]        new_byte;
  logic              addr_phase;
  logic              is_read;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] full_addr;
  logic              wel;
  logic [ADDR_W-1:0] rd_ptr;
  logic [6:0]        out_sh;
  logic [2:0]        obit;
  logic [7:0]        byte_src;
  logic              so_r, so_oe_r;
  logic [BASE_W-1:0] sec_base;
  logic [SEC_W:0]    wptr;
  logic [SEC_W:0]    nbytes;
  logic              ovf;
  logic [7:0]        stat_byte;
  logic              stat_got;
  logic              stat_wr_r;
  logic [7:0]        stat_wdata_r;
  logic              fault_r;
  logic              copy_active;
  logic [SEC_W-1:0]  copy_idx;
  logic              timer_busy;
  logic              byte_done;
  logic              prog_commit, stat_commit;
  logic              sbuf_we;
  logic [7:0]        sbuf [SECTOR_BYTES];
  logic [7:0]        mem_rdata;

  assign new_byte  = {shreg, si_q};
  assign full_addr = {addr_hi, new_byte};
  assign byte_done = sck_rise && (bit_cnt == 3'd7) && !cs_rise && !cs_fall
                     && (state != ST_IDLE);

  assign prog_commit = cs_rise && (state == ST_PROG) && (bit_cnt == 3'd0)
                       && !ovf && (nbytes == FULL_CNT);
  assign stat_commit = cs_rise && (state == ST_WSTAT) && (bit_cnt == 3'd0)
                       && stat_got;

  assign busy     = timer_busy | copy_active;
  assign byte_src = (state == ST_READ) ? mem_rdata
                                       : (busy ? 8'hFF : stat_rdata);

  // ---------------------------------------------------------------
  // transfer sequencer
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      addr_phase   <= 1'b0;
      is_read      <= 1'b0;
      addr_hi      <= '0;
      wel          <= 1'b0;
      rd_ptr       <= '0;
      out_sh       <= '0;
      obit         <= '0;
      so_r         <= 1'b0;
      so_oe_r      <= 1'b0;
      sec_base     <= '0;
      wptr         <= '0;
      nbytes       <= '0;
      ovf          <= 1'b0;
      stat_byte    <= '0;
      stat_got     <= 1'b0;
      stat_wr_r    <= 1'b0;
      stat_wdata_r <= '0;
      fault_r      <= 1'b0;
      copy_active  <= 1'b0;
      copy_idx     <= '0;
    end else begin
      stat_wr_r <= 1'b0;

      if (copy_active) begin
        copy_idx <= copy_idx + 1'b1;
        if (copy_idx == LAST_IDX) copy_active <= 1'b0;
      end

      if (cs_fall) begin
        state      <= ST_CMD;
        bit_cnt    <= '0;
        obit       <= '0;
        addr_phase <= 1'b0;
        fault_r    <= 1'b0;
      end else if (cs_rise) begin
        state <= ST_IDLE;
        if (prog_commit) begin
          copy_active <= 1'b1;
          copy_idx    <= '0;
          wel         <= 1'b0;
        end else if (state == ST_PROG && bit_cnt == 3'd0) begin
          fault_r <= 1'b1;
        end
        if (stat_commit) begin
          stat_wr_r    <= 1'b1;
          stat_wdata_r <= stat_byte;
          wel          <= 1'b0;
        end
      end else if (state != ST_IDLE) begin
        if (sck_rise) begin
          shreg   <= new_byte[6:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            unique case (state)
              ST_CMD: begin
                if (new_byte == OP_WEN_SET) begin
                  wel   <= 1'b1;
                  state <= ST_SKIP;
                end else if (new_byte == OP_WEN_CLR) begin
                  wel   <= 1'b0;
                  state <= ST_SKIP;
                end else if (new_byte == OP_STAT_RD) begin
                  state <= ST_STAT;
                end else if (new_byte == OP_STAT_WR) begin
                  stat_got <= 1'b0;
                  state    <= (wel && !busy) ? ST_WSTAT : ST_SKIP;
                end else if (new_byte == OP_READ) begin
                  is_read <= 1'b1;
                  state   <= ST_ADDR;
                end else if (new_byte == OP_PROG && wel && !busy) begin
                  is_read <= 1'b0;
                  state   <= ST_ADDR;
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_ADDR: begin
                if (!addr_phase) begin
                  addr_hi    <= new_byte[HI_W-1:0];
                  addr_phase <= 1'b1;
                end else if (is_read) begin
                  rd_ptr <= full_addr;
                  state  <= ST_READ;
                end else begin
                  sec_base <= full_addr[ADDR_W-1:SEC_W];
                  wptr     <= {1'b0, full_addr[SEC_W-1:0]};
                  nbytes   <= '0;
                  ovf      <= 1'b0;
                  state    <= ST_PROG;
                end
              end
              ST_PROG: begin
                if (wptr[SEC_W]) ovf  <= 1'b1;
                else             wptr <= wptr + 1'b1;
                if (nbytes != FULL_CNT) nbytes <= nbytes + 1'b1;
              end
              ST_WSTAT: begin
                stat_byte <= new_byte;
                stat_got  <= 1'b1;
              end
              default: ;
            endcase
          end
        end

        if (sck_fall && (state == ST_READ || state == ST_STAT)) begin
          obit <= obit + 1'b1;
          if (obit == 3'd0) begin
            so_r   <= byte_src[7];
            out_sh <= byte_src[6:0];
            if (state == ST_READ) rd_ptr <= rd_ptr + 1'b1;
          end else begin
            so_r   <= out_sh[6];
            out_sh <= {out_sh[5:0], 1'b0};
          end
        end
      end

      so_oe_r <= !cs_q && (state == ST_READ || state == ST_STAT);
    end
  end

  // sector staging buffer, no reset
  assign sbuf_we = byte_done && (state == ST_PROG) && !wptr[SEC_W];

  always_ff @(posedge clk) begin
    if (sbuf_we) sbuf[wptr[SEC_W-1:0]] <= new_byte;
  end

  spi_mem_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk   (clk),
    .we    (copy_active),
    .waddr ({sec_base, copy_idx}),
    .wdata (sbuf[copy_idx]),
    .raddr (rd_ptr),
    .rdata (mem_rdata)
  );

  spi_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (prog_commit | stat_commit),
    .busy  (timer_busy)
  );

  assign so         = so_r;
  assign so_oe      = so_oe_r;
  assign stat_wr    = stat_wr_r;
  assign stat_wdata = stat_wdata_r;
  assign prog_fault = fault_r;

  // ---------------------------------------------------------------
  // assertions
  // ---------------------------------------------------------------
  assert_hiz_deselected_R2: assert property (
    @(posedge clk) disable iff (rst) cs_q |=> !so_oe
  );

  assert_wel_cleared_R7: assert property (
    @(posedge clk) disable iff (rst) prog_commit |=> !wel
  );

  assert_fault_without_copy_R9: assert property (
    @(posedge clk) disable iff (rst) $rose(prog_fault) |-> !copy_active
  );

  assert_prog_blocked_busy_R10: assert property (
    @(posedge clk) disable iff (rst)
      (byte_done && state == ST_CMD && new_byte == OP_PROG && busy)
      |=> (state == ST_SKIP)
  );

  assert_stat_wr_pulse_R12: assert property (
    @(posedge clk) disable iff (rst) stat_wr |=> !stat_wr
  );

endmodule

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;

  localparam int HP     = 8;
  localparam int PCYC   = 3000;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n, sck, si;
  logic       so, so_oe;
  logic [7:0] stat_model;
  logic       stat_wr;
  logic [7:0] stat_wdata;
  logic       busy, prog_fault;

  int  checks = 0;
  int  errors = 0;
  int  pause_clks = 0;
  bit  oe_seen = 1'b0;
  logic [7:0] exp_mem [512];

  always #4 clk = ~clk;

  spi_mem_slave #(.PROG_CYCLES(PCYC)) dut (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sck        (sck),
    .si         (si),
    .so         (so),
    .so_oe      (so_oe),
    .stat_rdata (stat_model),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .busy       (busy),
    .prog_fault (prog_fault)
  );

  // protection-controller stand-in
  always @(posedge clk) begin
    if (rst) stat_model <= 8'h00;
    else if (stat_wr) stat_model <= stat_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_high();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(3 * HP);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      si = tx[i];
      wait_clk(HP + pause_clks);
      rx[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic tx8(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, 8, dummy);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_low();
    tx8(op);
    cs_high();
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (busy && guard < 20000) begin
      wait_clk(1);
      guard++;
    end
  endtask

  task automatic prog_burst(input logic [15:0] addr, input int n, input logic [7:0] base,
                            input int extra_bits, input bit enable);
    if (enable) cmd1(8'h06);
    cs_low();
    tx8(8'h02);
    tx8(addr[15:8]);
    tx8(addr[7:0]);
    for (int k = 0; k < n; k++) tx8(base + 8'(k));
    if (extra_bits > 0) begin
      logic [7:0] dummy;
      xfer(8'h5A, extra_bits, dummy);
    end
    cs_high();
  endtask

  task automatic set_exp(input int addr, input logic [7:0] base);
    for (int k = 0; k < 16; k++) exp_mem[(addr + k) % 512] = base + 8'(k);
  endtask

  task automatic read_check(input logic [15:0] addr, input int n, input string req);
    logic [7:0] rx;
    int a;
    a = int'(addr[8:0]);
    cs_low();
    tx8(8'h03);
    tx8(addr[15:8]);
    tx8(addr[7:0]);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk(req, rx, exp_mem[a]);
      a = (a + 1) % 512;
    end
    cs_high();
  endtask

  task automatic stat_read(input int n, output logic [7:0] last, output logic [7:0] first);
    logic [7:0] rx;
    cs_low();
    tx8(8'h05);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      if (k == 0) first = rx;
      last = rx;
    end
    cs_high();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_arming();
    chk("R3 busy after reset", busy, 1'b0);
    chk("R3 prog_fault after reset", prog_fault, 1'b0);
    chk("R3 so_oe after reset", so_oe, 1'b0);
    oe_seen = 1'b0;
    tx8(8'h03); tx8(8'h00); tx8(8'h20); tx8(8'h00); tx8(8'h00);
    chk("R3 no decode before CS fall", oe_seen, 1'b0);
    cs_n = 1'b1;
    wait_clk(3 * HP);
  endtask

  task automatic t_output_enable();
    chk("R2 so_oe idle", so_oe, 1'b0);
    cs_low();
    tx8(8'h05);
    wait_clk(HP);
    chk("R2 so_oe during status read", so_oe, 1'b1);
    cs_high();
    chk("R2 so_oe after CS high", so_oe, 1'b0);
  endtask

  task automatic t_program_basic();
    prog_burst(16'h0020, 16, 8'hA0, 0, 1'b1);
    set_exp(16'h020, 8'hA0);
    chk("R10 busy after commit", busy, 1'b1);
    chk("R7 no fault on full burst", prog_fault, 1'b0);
    wait_ready();
    read_check(16'h0020, 16, "R7 R4 R1 sector readback");
    // write enable was consumed by the commit
    prog_burst(16'h0020, 16, 8'h10, 0, 1'b0);
    chk("R6 no busy without write enable", busy, 1'b0);
    read_check(16'h0020, 2, "R6 R7 unchanged without write enable");
  endtask

  task automatic t_abort_and_fault();
    prog_burst(16'h0040, 16, 8'h40, 0, 1'b1);
    set_exp(16'h040, 8'h40);
    wait_ready();
    prog_burst(16'h0040, 15, 8'hC0, 4, 1'b1);
    chk("R8 no fault on mid-byte CS rise", prog_fault, 1'b0);
    chk("R8 no busy on mid-byte CS rise", busy, 1'b0);
    read_check(16'h004E, 2, "R8 array unchanged");
    prog_burst(16'h0040, 10, 8'hC0, 0, 1'b0);
    cmd1(8'h04);
    prog_burst(16'h0040, 10, 8'hC0, 0, 1'b1);
    chk("R9 fault on short burst", prog_fault, 1'b1);
    chk("R9 no busy on short burst", busy, 1'b0);
    prog_burst(16'h0044, 16, 8'hD0, 0, 1'b1);
    chk("R9 fault on sector overrun", prog_fault, 1'b1);
    read_check(16'h0040, 16, "R9 array unchanged");
    cs_low();
    chk("R9 fault cleared at CS fall", prog_fault, 1'b0);
    cs_high();
  endtask

  task automatic t_read_wrap();
    prog_burst(16'h01F0, 16, 8'h70, 0, 1'b1);
    set_exp(16'h1F0, 8'h70);
    wait_ready();
    prog_burst(16'h0000, 16, 8'h30, 0, 1'b1);
    set_exp(16'h000, 8'h30);
    wait_ready();
    read_check(16'h01FE, 4, "R5 wrap 1FF to 000");
    read_check(16'hFE21, 2, "R4 upper address bits ignored");
    pause_clks = 90;
    read_check(16'h01FF, 2, "R14 paused clock read");
    pause_clks = 0;
  endtask

  task automatic t_status();
    logic [7:0] last, first;
    cmd1(8'h06);
    cs_low(); tx8(8'h01); tx8(8'h05); cs_high();
    chk("R12 status byte delivered", stat_model, 8'h05);
    chk("R10 busy after status write", busy, 1'b1);
    stat_read(1, last, first);
    chk("R11 status reads FF while busy", first, 8'hFF);
    wait_ready();
    stat_read(2, last, first);
    chk("R11 status first byte", first, 8'h05);
    chk("R11 status repeats", last, 8'h05);
    cmd1(8'h06);
    cmd1(8'h04);
    cs_low(); tx8(8'h01); tx8(8'h03); cs_high();
    chk("R12 write enable cleared by 0x04", stat_model, 8'h05);
    cs_low(); tx8(8'h01); tx8(8'h02); cs_high();
    chk("R6 status write needs enable", stat_model, 8'h05);
  endtask

  task automatic t_busy_block();
    prog_burst(16'h0060, 16, 8'h60, 0, 1'b1);
    set_exp(16'h060, 8'h60);
    prog_burst(16'h0060, 16, 8'hE0, 0, 1'b1);
    wait_ready();
    read_check(16'h0060, 16, "R10 program while busy ignored");
  endtask

  task automatic t_unknown();
    oe_seen = 1'b0;
    cs_low();
    tx8(8'hAB); tx8(8'h03); tx8(8'h00); tx8(8'h60); tx8(8'h00);
    cs_high();
    chk("R13 SO disabled after unknown opcode", oe_seen, 1'b0);
    chk("R13 no busy after unknown opcode", busy, 1'b0);
    read_check(16'h0060, 1, "R13 recovery after CS high");
  endtask

  initial begin
    rst  = 1'b1;
    cs_n = 1'b0;   // held low through reset for the arming check
    sck  = 1'b0;
    si   = 1'b0;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);
    t_reset_arming();
    t_output_enable();
    t_program_basic();
    t_abort_and_fault();
    t_read_wrap();
    t_status();
    t_busy_block();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule